// File: doc/BRIEF.md
# Block-Transfer Configuration Register Slave

A two-wire serial slave that holds a bank of 21 byte-wide configuration registers and presents all of them in parallel to the surrounding logic. A host loads the bank with one sequential block write. After the device address, the first two bytes are a command byte and a length byte. The slave acknowledges both and discards them. Every byte after that lands in the next register, starting from register 0. There is no register pointer and no random access.

A block read returns a length byte first, taken from the count register (index 8). The registers then follow from index 0. The count register sets how far a read can reach. One register (index 7) carries a fixed identification value that the host cannot change. The serial lines are brought into the system clock domain through synchronizers, and the slave drives its data line only by pulling it low.

Top module: `cfg_i2c_slave`

## Requirements
- R1: After reset, every register reads 0x00 except index 7 = 0x91, index 8 = 0x08 and index 9 = 0x10, and the slave leaves the data line released (sda_oe_o = 0).
- R2: Only the 8-bit address bytes 0xD2 (write) and 0xD3 (read) are acknowledged. After any other address the slave leaves the data line released until the next START.
- R3: In a write, the slave acknowledges the two bytes that follow the address and discards them. Each later byte is acknowledged and stored into registers 0, 1, 2 and so on, in order.
- R4: Write data bytes beyond register 20 are acknowledged and change no register.
- R5: Register 7 always reads 0x91 (upper nibble 1001, lower nibble revision 0x1). Writes to it have no effect, though the write position still advances past it.
- R6: A write of 0x00 into register 8 is ignored, and the register keeps its previous value. Any other value is stored.
- R7: A read first returns the value of register 8 (N). It then returns registers 0 through min(N, 20) in order. Every byte after that reads 0xFF.
- R8: A NACK from the master after a read byte ends the transfer. The slave releases the data line and stays released until the next START.
- R9: START and STOP are recognized only as data-line transitions while the clock line is high. A STOP returns the slave to idle. A repeated START begins a new address phase, and the write position restarts at register 0.
- R10: The slave changes its data-line drive only while the synchronized clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to sample the serial lines |
| rst_ni | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | 1 pulls the data line low; 0 releases it |
| cfg_o | output | 168 | Register bank; register k is bits [8k+7:8k] |

## Verification
The assertions run on every cycle. They check that a START always leads to the address phase and a STOP always leads to idle. They check that the drive on the data line is off in idle and changes only while the clock is low. They also check that register 7 never changes and that register 8 never becomes zero. Only the bench scenarios can show the transfers themselves. These cover the skipping of the header bytes, the write ordering, data discarded past the last register, the count byte and how far reads reach, the 0xFF fill, and NACK and repeated-START handling. The bench compares the whole bank against its model whenever the bus is idle.

// File: rtl/cfg_i2c_pkg.sv
package cfg_i2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK
  } bus_st_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic rise_o,
  output logic fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_d  <= scl_ff[STAGES-1];
      sda_d  <= sda_ff[STAGES-1];
    end
  end

  assign scl_o   = scl_ff[STAGES-1];
  assign sda_o   = sda_ff[STAGES-1];
  assign rise_o  = scl_o & ~scl_d;
  assign fall_o  = ~scl_o & scl_d;
  assign start_o = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o  = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile #(
  parameter int          NUM_REGS = 21,
  parameter int          PW       = 5,
  parameter int          RO_IDX   = 7,
  parameter logic [7:0]  RO_VAL   = 8'h91,
  parameter int          CNT_IDX  = 8,
  parameter logic [7:0]  CNT_RST  = 8'h08,
  parameter int          WDT_IDX  = 9,
  parameter logic [7:0]  WDT_RST  = 8'h10
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [PW-1:0]         wr_addr_i,
  input  logic [7:0]            wr_data_i,
  input  logic [PW-1:0]         rd_addr_i,
  output logic [7:0]            rd_data_o,
  output logic [NUM_REGS*8-1:0] regs_o
);
  logic [7:0] regs [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    localparam logic [7:0] RST_V = (g == CNT_IDX) ? CNT_RST :
                                   (g == WDT_IDX) ? WDT_RST : 8'h00;
    if (g == RO_IDX) begin : g_ro
      assign regs[g] = RO_VAL;
    end else begin : g_rw
      logic wr_hit;
      assign wr_hit = wr_en_i && (wr_addr_i == PW'(g)) &&
                      !((g == CNT_IDX) && (wr_data_i == 8'h00));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     regs[g] <= RST_V;
        else if (wr_hit) regs[g] <= wr_data_i;
      end
    end
    assign regs_o[g*8 +: 8] = regs[g];
  end

  assign rd_data_o = (int'(rd_addr_i) < NUM_REGS) ? regs[rd_addr_i] : 8'hFF;
endmodule

// File: rtl/i2c_cfg_fsm.sv
module i2c_cfg_fsm
  import cfg_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h69,
  parameter int         NUM_REGS = 21,
  parameter int         PW       = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sda_i,
  input  logic          rise_i,
  input  logic          fall_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [7:0]    cnt_i,
  input  logic [7:0]    rd_data_i,
  output logic [PW-1:0] rd_addr_o,
  output logic          wr_en_o,
  output logic [PW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic          sda_oe_o,
  output bus_st_e       state_o
);
  localparam logic [7:0] LAST_IDX = 8'(NUM_REGS - 1);

  bus_st_e       state;
  logic [3:0]    bit_cnt;
  logic [7:0]    shreg, tx;
  logic [1:0]    hdr_cnt;
  logic [PW-1:0] wptr, rptr;
  logic          rd_mode, rd_first, nack;
  logic [7:0]    rd_last, tx_next;

  assign rd_last   = (cnt_i > LAST_IDX) ? LAST_IDX : cnt_i;
  assign tx_next   = rd_first ? cnt_i :
                     (8'(rptr) <= rd_last) ? rd_data_i : 8'hFF;
  assign rd_addr_o = rptr;
  assign state_o   = state;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      tx       <= '0;
      hdr_cnt  <= '0;
      wptr     <= '0;
      rptr     <= '0;
      rd_mode  <= 1'b0;
      rd_first <= 1'b0;
      nack     <= 1'b0;
      sda_oe_o <= 1'b0;
      wr_en_o  <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      wr_en_o <= 1'b0;
      if (start_i) begin
        state    <= ST_ADDR;
        bit_cnt  <= '0;
        sda_oe_o <= 1'b0;
      end else if (stop_i) begin
        state    <= ST_IDLE;
        sda_oe_o <= 1'b0;
      end else begin
        unique case (state)
          ST_ADDR, ST_WR: begin
            if (rise_i && bit_cnt < 4'd8) begin
              shreg   <= {shreg[6:0], sda_i};
              bit_cnt <= bit_cnt + 4'd1;
            end else if (fall_i && bit_cnt == 4'd8) begin
              bit_cnt <= '0;
              if (state == ST_ADDR) begin
                if (shreg[7:1] == DEV_ADDR) begin
                  state    <= ST_ADDR_ACK;
                  sda_oe_o <= 1'b1;
                  rd_mode  <= shreg[0];
                  hdr_cnt  <= '0;
                  wptr     <= '0;
                  rptr     <= '0;
                  rd_first <= 1'b1;
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                state    <= ST_WR_ACK;
                sda_oe_o <= 1'b1;
                if (hdr_cnt != 2'd2) begin
                  hdr_cnt <= hdr_cnt + 2'd1;
                end else if (int'(wptr) < NUM_REGS) begin
                  wr_en_o   <= 1'b1;
                  wr_addr_o <= wptr;
                  wr_data_o <= shreg;
                  wptr      <= wptr + 1'b1;
                end
              end
            end
          end
          ST_ADDR_ACK, ST_WR_ACK, ST_RD_ACK: begin
            if (rise_i) nack <= sda_i;
            if (fall_i) begin
              if ((state == ST_RD_ACK && !nack) ||
                  (state == ST_ADDR_ACK && rd_mode)) begin
                state    <= ST_RD;
                tx       <= tx_next;
                sda_oe_o <= ~tx_next[7];
                if (rd_first)                     rd_first <= 1'b0;
                else if (int'(rptr) < NUM_REGS)   rptr <= rptr + 1'b1;
              end else begin
                sda_oe_o <= 1'b0;
                state    <= (state == ST_RD_ACK) ? ST_IDLE : ST_WR;
              end
            end
          end
          ST_RD: begin
            if (fall_i) begin
              if (bit_cnt == 4'd7) begin
                bit_cnt  <= '0;
                sda_oe_o <= 1'b0;
                state    <= ST_RD_ACK;
              end else begin
                bit_cnt  <= bit_cnt + 4'd1;
                tx       <= {tx[6:0], 1'b0};
                sda_oe_o <= ~tx[6];
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave
  import cfg_i2c_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         NUM_REGS    = 21,
  parameter int         RO_IDX      = 7,
  parameter logic [3:0] VENDOR_ID   = 4'b1001,
  parameter logic [3:0] REV_ID      = 4'h1,
  parameter int         CNT_IDX     = 8,
  parameter logic [7:0] CNT_RST     = 8'h08,
  parameter int         WDT_IDX     = 9,
  parameter logic [7:0] WDT_RST     = 8'h10,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  output logic [NUM_REGS*8-1:0] cfg_o
);
  localparam int PW = $clog2(NUM_REGS + 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en;
  logic [PW-1:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_data;
  bus_st_e bus_st;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .rise_o(scl_rise), .fall_o(scl_fall),
    .start_o(start_det), .stop_o(stop_det)
  );

  i2c_cfg_fsm #(.DEV_ADDR(DEV_ADDR), .NUM_REGS(NUM_REGS), .PW(PW)) u_fsm (
    .clk_i, .rst_ni, .sda_i(sda_s), .rise_i(scl_rise), .fall_i(scl_fall),
    .start_i(start_det), .stop_i(stop_det), .cnt_i(cfg_o[CNT_IDX*8 +: 8]),
    .rd_data_i(rd_data), .rd_addr_o(rd_addr), .wr_en_o(wr_en),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .sda_oe_o, .state_o(bus_st)
  );

  cfg_regfile #(
    .NUM_REGS(NUM_REGS), .PW(PW), .RO_IDX(RO_IDX), .RO_VAL({VENDOR_ID, REV_ID}),
    .CNT_IDX(CNT_IDX), .CNT_RST(CNT_RST), .WDT_IDX(WDT_IDX), .WDT_RST(WDT_RST)
  ) u_regs (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .regs_o(cfg_o)
  );
endmodule

// File: rtl/cfg_i2c_slave_chk.sv
module cfg_i2c_slave_chk
  import cfg_i2c_pkg::*;
#(
  parameter logic [3:0] VENDOR_ID = 4'b1001
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_i,
  input logic       sda_oe_i,
  input bus_st_e    state_i,
  input logic       start_i,
  input logic       stop_i,
  input logic [7:0] ro_byte_i,
  input logic [7:0] cnt_byte_i
);
  p_start_addr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> state_i == ST_ADDR);
  p_stop_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> state_i == ST_IDLE);
  p_idle_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i == ST_IDLE |-> !sda_oe_i);
  p_drive_scl_low_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_i) |-> !scl_i);
  p_ro_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(ro_byte_i) && ro_byte_i[7:4] == VENDOR_ID);
  p_cnt_nonzero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_byte_i != 8'h00);
endmodule

bind cfg_i2c_slave cfg_i2c_slave_chk #(.VENDOR_ID(VENDOR_ID)) u_chk (
  .clk_i, .rst_ni, .scl_i(scl_s), .sda_oe_i(sda_oe_o), .state_i(bus_st),
  .start_i(start_det), .stop_i(stop_det),
  .ro_byte_i(cfg_o[RO_IDX*8 +: 8]), .cnt_byte_i(cfg_o[CNT_IDX*8 +: 8])
);

// File: tb/tb_cfg_i2c_slave.sv
module tb_cfg_i2c_slave;
  localparam int N = 21;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic m_scl_lo = 1'b0, m_sda_lo = 1'b0;
  logic sda_oe;
  logic [N*8-1:0] cfg;
  logic scl_line, sda_line;
  logic bus_idle = 1'b0;
  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [7:0] mdl [N];

  assign scl_line = ~m_scl_lo;
  assign sda_line = ~(m_sda_lo | sda_oe);

  always #4 clk = ~clk;

  cfg_i2c_slave dut (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl_line), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .cfg_o(cfg)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // model comparison on every clock while the bus is idle
  always @(negedge clk) begin
    cyc++;
    if (rst_ni && bus_idle) begin
      for (int i = 0; i < N; i++)
        check(cfg[i*8 +: 8] == mdl[i], "R3 bank", cfg[i*8 +: 8], mdl[i]);
      check(!sda_oe, "R8 idle release", sda_oe, 0);
    end
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic wq(); repeat (Q) @(posedge clk); endtask

  task automatic bus_start();
    bus_idle = 1'b0;
    m_sda_lo = 1'b0; wq(); m_scl_lo = 1'b0; wq();
    m_sda_lo = 1'b1; wq(); m_scl_lo = 1'b1; wq();
  endtask

  task automatic bus_stop();
    m_sda_lo = 1'b1; wq(); m_scl_lo = 1'b0; wq();
    m_sda_lo = 1'b0; wq(); wq();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda_lo = ~b[i]; wq(); m_scl_lo = 1'b0; wq(); m_scl_lo = 1'b1; wq();
    end
    m_sda_lo = 1'b0; wq(); m_scl_lo = 1'b0; wq();
    ack = ~sda_line;
    m_scl_lo = 1'b1; wq();
  endtask

  task automatic recv_byte(input bit last, output logic [7:0] b);
    m_sda_lo = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      wq(); m_scl_lo = 1'b0; wq(); b[i] = sda_line; m_scl_lo = 1'b1;
    end
    m_sda_lo = ~last; wq(); m_scl_lo = 1'b0; wq(); m_scl_lo = 1'b1; wq();
    m_sda_lo = 1'b0;
  endtask

  function automatic void mdl_write(input int idx, input logic [7:0] d);
    if (idx < N && idx != 7 && !(idx == 8 && d == 8'h00)) mdl[idx] = d;
  endfunction

  function automatic logic [7:0] exp_read(input int k);
    int last;
    if (k == 0) return mdl[8];
    last = (mdl[8] > N - 1) ? N - 1 : int'(mdl[8]);
    return (k - 1 <= last) ? mdl[k-1] : 8'hFF;
  endfunction

  task automatic wr_txn(input logic [7:0] d[$], input string req);
    bit ack;
    bus_start();
    send_byte(8'hD2, ack); check(ack, "R2 write addr ack", ack, 1);
    send_byte(8'hA5, ack); check(ack, "R3 cmd ack", ack, 1);
    send_byte(8'h5A, ack); check(ack, "R3 count ack", ack, 1);
    foreach (d[i]) begin
      send_byte(d[i], ack);
      check(ack, req, ack, 1);
      mdl_write(i, d[i]);
    end
    bus_stop();
    bus_idle = 1'b1; wq();
  endtask

  task automatic rd_txn(input int n, input string req);
    bit ack;
    logic [7:0] b;
    bus_start();
    send_byte(8'hD3, ack); check(ack, "R2 read addr ack", ack, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k == n - 1, b);
      check(b == exp_read(k), req, b, exp_read(k));
    end
    wq(); check(!sda_oe, "R8 released after nack", sda_oe, 0);
    bus_stop();
    bus_idle = 1'b1; wq();
  endtask

  initial begin
    logic [7:0] d[$];
    bit ack;
    logic [7:0] b;
    for (int i = 0; i < N; i++) mdl[i] = 8'h00;
    mdl[7] = 8'h91; mdl[8] = 8'h08; mdl[9] = 8'h10;
    m_scl_lo = 1'b0; m_sda_lo = 1'b0;
    repeat (5) @(posedge clk);
    rst_ni = 1'b1;
    wq();
    // R1 reset state
    for (int i = 0; i < N; i++)
      check(cfg[i*8 +: 8] == mdl[i], "R1 reset value", cfg[i*8 +: 8], mdl[i]);
    check(!sda_oe, "R1 released", sda_oe, 0);
    bus_idle = 1'b1; wq();

    // R3 short write
    d = {8'h11, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66};
    wr_txn(d, "R3 data ack");
    check(cfg[15:0] == 16'h2211, "R3 first bytes", cfg[15:0], 16'h2211);

    // R2 wrong address: no ack, no drive afterwards
    bus_start();
    send_byte(8'hA0, ack); check(!ack, "R2 foreign addr nack", ack, 0);
    send_byte(8'h00, ack); check(!ack, "R2 stays released", ack, 0);
    bus_stop(); bus_idle = 1'b1; wq();

    // R4 R5 long write, byte7 attempted, count 0x0C
    d.delete();
    for (int i = 0; i < N + 3; i++) d.push_back(8'(8'h30 + i));
    d[7] = 8'h00; d[8] = 8'h0C;
    wr_txn(d, "R4 ack past end");
    check(cfg[7*8 +: 8] == 8'h91, "R5 ro byte", cfg[7*8 +: 8], 8'h91);
    check(cfg[20*8 +: 8] == 8'h44, "R4 last reg", cfg[20*8 +: 8], 8'h44);

    // R6 zero into count register ignored
    d.delete();
    for (int i = 0; i < 9; i++) d.push_back(8'(8'hC0 + i));
    d[8] = 8'h00;
    wr_txn(d, "R6 data ack");
    check(cfg[8*8 +: 8] == 8'h0C, "R6 count kept", cfg[8*8 +: 8], 8'h0C);

    // R7 read with count 12, runs 2 past reach into 0xFF fill, R8 nack
    rd_txn(16, "R7 read data");

    // R7 count 20: full reach plus fill, R5 read of id
    d.delete();
    for (int i = 0; i < 9; i++) d.push_back(8'(8'h70 + i));
    d[8] = 8'h14;
    wr_txn(d, "R3 data ack");
    rd_txn(N + 3, "R7 full read");

    // R7 minimal count 1
    d.delete();
    for (int i = 0; i < 9; i++) d.push_back(8'(8'hE0 + i));
    d[8] = 8'h01;
    wr_txn(d, "R3 data ack");
    rd_txn(5, "R7 short reach");

    // R9 repeated start: write byte0, restart as read
    bus_start();
    send_byte(8'hD2, ack); send_byte(8'h00, ack); send_byte(8'h00, ack);
    send_byte(8'h9E, ack); check(ack, "R9 data ack", ack, 1);
    mdl_write(0, 8'h9E);
    m_sda_lo = 1'b0; wq(); m_scl_lo = 1'b0; wq();
    bus_start();
    send_byte(8'hD3, ack); check(ack, "R9 restart addr ack", ack, 1);
    recv_byte(1'b0, b); check(b == mdl[8], "R9 count after restart", b, mdl[8]);
    recv_byte(1'b1, b); check(b == 8'h9E, "R9 byte0 after restart", b, 8'h9E);
    bus_stop(); bus_idle = 1'b1; wq();

    // R9 write aborted by STOP then a new write starts again at byte 0
    bus_start();
    send_byte(8'hD2, ack); send_byte(8'h00, ack); send_byte(8'h00, ack);
    send_byte(8'h12, ack); mdl_write(0, 8'h12);
    bus_stop(); bus_idle = 1'b1; wq();
    d = {8'h34};
    wr_txn(d, "R9 data ack");
    check(cfg[7:0] == 8'h34, "R9 restart at byte0", cfg[7:0], 8'h34);

    // R9 data toggles while clock is low do not start a transfer
    bus_idle = 1'b0;
    m_scl_lo = 1'b1; wq();
    m_sda_lo = 1'b1; wq(); m_sda_lo = 1'b0; wq();
    m_scl_lo = 1'b0; wq();
    check(!sda_oe, "R9 no false start", sda_oe, 0);
    bus_idle = 1'b1;
    repeat (20) @(posedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule